// File: doc/BRIEF.md
# Conditional Skip Evaluator

This block decides whether a skip-group instruction should cause the program counter logic to step over the next instruction. Each instruction word arrives together with a snapshot of the accumulator, the in-out register, the overflow flag and the sense-switch inputs, as one transfer on a valid/ready input channel. The block decodes the word and evaluates every condition the word selects. It returns one registered result, carrying the skip decision, on a valid/ready output channel.

A word may select several register tests and any number of sense switches at once. The selected conditions are ORed together, and a separate invert bit then reverses the result. A word whose opcode bits do not match the skip pattern is still accepted, but it yields no skip. When a word selects the overflow test, the block raises a one-cycle overflow-clear pulse as its result is consumed, so the flag owner can reset the flag.

Back-pressure works as follows. The input is accepted only when `in_ready` is high. `in_ready` is high whenever the output register is empty, or is being drained in the same cycle. While `res_valid` is high and `res_ready` is low, the result is held unchanged. Fetch and program counter arithmetic belong to the surrounding logic.

Top module: `skip_evaluator`

## Requirements
- R1: After reset, `res_valid` and `ovf_clear` are low and `in_ready` is high.
- R2: A word counts as a skip instruction only when `instr[23:19]` equals 5'b11010. Any other word gives `res_skip`=0 and never raises `ovf_clear`.
- R3: `instr[8]` selects the test "accumulator equals zero".
- R4: `instr[9]` selects "accumulator not negative", and `instr[10]` selects "accumulator negative". The sign of each register is its bit 23.
- R5: `instr[11]` selects the test "overflow flag clear".
- R6: `instr[12]` selects the test "in-out register not negative".
- R7: `instr[7:0]` is a sense-switch select mask. The switch condition is true when any selected bit of `sense_sw` is high.
- R8: All selected conditions are ORed together, and `instr[18]` (the invert bit) then inverts that OR to form `res_skip`.
- R9: When a skip word selects no condition and no switch, `res_skip` equals the invert bit.
- R10: A transfer is accepted when `in_valid` and `in_ready` are both high, and its result appears on the next cycle with `res_valid` high. `in_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, `res_skip` stays stable.
- R11: `ovf_clear` is high for exactly the cycle in which a result is consumed (`res_valid && res_ready`), and only if that result's skip word had `instr[11]` set. This holds whether or not the word skips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer valid |
| in_ready | output | 1 | Input transfer accepted when high |
| instr | input | 24 | Instruction word, bit 23 is the leading bit |
| acc | input | 24 | Accumulator snapshot |
| io_reg | input | 24 | In-out register snapshot |
| ovf | input | 1 | Overflow flag |
| sense_sw | input | 8 | Sense-switch inputs |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_skip | output | 1 | Skip decision |
| ovf_clear | output | 1 | Overflow-clear pulse on result consumption |

## Verification
The bench aims at several corner cases, and each has a visible failure mode:
- An accumulator of exactly zero with both sign tests selected. A design that treats zero as negative would flip this decision.
- A word with nothing selected, tried both with and without the invert bit. A design that applies the invert only to a true OR would never skip here.
- Words whose opcode differs from the skip pattern in a single bit. A loose decoder would skip on these or pulse overflow-clear.
- A result held under back-pressure. A design that let the result change or pulsed overflow-clear while stalled would be caught here, as would one that keeps `in_ready` high while stalled and so loses data.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int NCOND = 5;
  localparam logic [4:0] SKIP_OPCODE = 5'b11010;

  // condition indices within the condition field
  localparam int C_AC_ZERO = 0;
  localparam int C_AC_POS  = 1;
  localparam int C_AC_NEG  = 2;
  localparam int C_OV_CLR  = 3;
  localparam int C_IO_POS  = 4;

  typedef struct packed {
    logic is_skip;
    logic invert;
    logic [NCOND-1:0] cond;
  } skip_dec_t;
endpackage

// File: rtl/skip_decode.sv
module skip_decode
  import skip_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int SW_W   = 8
) (
  input  logic [WORD_W-1:0] instr,
  output skip_dec_t         dec,
  output logic [SW_W-1:0]   sw_sel
);
  localparam int OP_HI   = WORD_W - 1;
  localparam int OP_LO   = WORD_W - 5;
  localparam int INV_BIT = WORD_W - 6;
  localparam int COND_LO = SW_W;
  localparam int COND_HI = SW_W + NCOND - 1;

  always_comb begin
    dec.is_skip = (instr[OP_HI:OP_LO] == SKIP_OPCODE);
    dec.invert  = instr[INV_BIT];
    dec.cond    = instr[COND_HI:COND_LO];
    sw_sel      = instr[SW_W-1:0];
  end
endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skip_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int SW_W   = 8
) (
  input  skip_dec_t         dec,
  input  logic [SW_W-1:0]   sw_sel,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] io_reg,
  input  logic              ovf,
  input  logic [SW_W-1:0]   sense_sw,
  output logic              skip,
  output logic              ovc
);
  localparam int SIGN = WORD_W - 1;

  logic [NCOND-1:0] term;
  logic [NCOND-1:0] hit_vec;
  logic             any_hit;

  always_comb begin
    term            = '0;
    term[C_AC_ZERO] = (acc == '0);
    term[C_AC_POS]  = ~acc[SIGN];
    term[C_AC_NEG]  = acc[SIGN];
    term[C_OV_CLR]  = ~ovf;
    term[C_IO_POS]  = ~io_reg[SIGN];
  end

  genvar g;
  generate
    for (g = 0; g < NCOND; g++) begin : g_term
      assign hit_vec[g] = dec.cond[g] & term[g];
    end
  endgenerate

  assign any_hit = (|hit_vec) | (|(sw_sel & sense_sw));
  assign skip    = dec.is_skip & (any_hit ^ dec.invert);
  assign ovc     = dec.is_skip & dec.cond[C_OV_CLR];
endmodule

// File: rtl/skip_out_stage.sv
module skip_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic skip_d,
  input  logic ovc_d,
  output logic res_valid,
  input  logic res_ready,
  output logic res_skip,
  output logic ovf_clear
);
  logic ovc_q;
  logic accept;

  assign in_ready = ~res_valid | res_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_skip  <= 1'b0;
      ovc_q     <= 1'b0;
    end else begin
      if (accept) begin
        res_valid <= 1'b1;
        res_skip  <= skip_d;
        ovc_q     <= ovc_d;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

  assign ovf_clear = res_valid & res_ready & ovc_q;

  // R10
  held_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_skip)));

  // R10
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> res_valid);

  // R11
  ovc_only_on_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clear |-> (res_valid && res_ready));

  // R10
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !in_ready);
endmodule

// File: rtl/skip_evaluator.sv
module skip_evaluator
  import skip_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int SW_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] io_reg,
  input  logic              ovf,
  input  logic [SW_W-1:0]   sense_sw,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_skip,
  output logic              ovf_clear
);
  skip_dec_t       dec;
  logic [SW_W-1:0] sw_sel;
  logic            skip_d;
  logic            ovc_d;

  skip_decode #(.WORD_W(WORD_W), .SW_W(SW_W)) u_dec (
    .instr (instr),
    .dec   (dec),
    .sw_sel(sw_sel)
  );

  skip_eval #(.WORD_W(WORD_W), .SW_W(SW_W)) u_eval (
    .dec     (dec),
    .sw_sel  (sw_sel),
    .acc     (acc),
    .io_reg  (io_reg),
    .ovf     (ovf),
    .sense_sw(sense_sw),
    .skip    (skip_d),
    .ovc     (ovc_d)
  );

  skip_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .skip_d   (skip_d),
    .ovc_d    (ovc_d),
    .res_valid(res_valid),
    .res_ready(res_ready),
    .res_skip (res_skip),
    .ovf_clear(ovf_clear)
  );

  // R2
  non_skip_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec.is_skip) |-> (!skip_d && !ovc_d));

  // R9
  empty_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.is_skip && dec.cond == '0 && sw_sel == '0) |-> (skip_d == dec.invert));
endmodule

// File: tb/test_skip_evaluator.sv
module test_skip_evaluator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] instr = '0;
  logic [23:0] acc = '0;
  logic [23:0] io_reg = '0;
  logic        ovf = 1'b0;
  logic [7:0]  sense_sw = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_skip;
  logic        ovf_clear;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  skip_evaluator i_skip_evaluator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .acc(acc), .io_reg(io_reg), .ovf(ovf), .sense_sw(sense_sw),
    .res_valid(res_valid), .res_ready(res_ready), .res_skip(res_skip),
    .ovf_clear(ovf_clear)
  );

  function automatic logic model_skip(logic [23:0] w, logic [23:0] a,
                                      logic [23:0] io, logic ov, logic [7:0] sw);
    logic hit;
    if (w[23:19] != 5'b11010) return 1'b0;
    hit = 1'b0;
    if (w[8]  && a == 24'd0) hit = 1'b1;
    if (w[9]  && !a[23])     hit = 1'b1;
    if (w[10] && a[23])      hit = 1'b1;
    if (w[11] && !ov)        hit = 1'b1;
    if (w[12] && !io[23])    hit = 1'b1;
    if ((w[7:0] & sw) != 8'd0) hit = 1'b1;
    return hit ^ w[18];
  endfunction

  function automatic logic model_ovc(logic [23:0] w);
    return (w[23:19] == 5'b11010) && w[11];
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one transfer with the consumer ready
  task automatic run(string req, logic [23:0] w, logic [23:0] a,
                     logic [23:0] io, logic ov, logic [7:0] sw);
    @(negedge clk);
    instr = w; acc = a; io_reg = io; ovf = ov; sense_sw = sw;
    in_valid = 1'b1; res_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, res_valid, 1'b1);
    check({req, " skip"}, res_skip, model_skip(w, a, io, ov, sw));
    check({req, " ovc"}, ovf_clear, model_ovc(w));
  endtask

  localparam logic [23:0] OPW = 24'hD0_0000; // bits 23:19 = 11010

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", res_valid, 1'b0);
    check("R1 ovc", ovf_clear, 1'b0);
    check("R1 ready", in_ready, 1'b1);
    rst_n = 1'b1;

    // R3 zero accumulator
    run("R3 zero", OPW | 24'h100, 24'd0, 24'd0, 1'b1, 8'd0);
    run("R3 nonzero", OPW | 24'h100, 24'd5, 24'd0, 1'b1, 8'd0);
    // R4 sign tests, zero is not negative
    run("R4 pos on zero", OPW | 24'h200, 24'd0, 24'd0, 1'b1, 8'd0);
    run("R4 neg on zero", OPW | 24'h400, 24'd0, 24'd0, 1'b1, 8'd0);
    run("R4 neg", OPW | 24'h400, 24'h800000, 24'd0, 1'b1, 8'd0);
    // R5 overflow test and R11 pulse
    run("R5 ov set", OPW | 24'h800, 24'd1, 24'd0, 1'b1, 8'd0);
    run("R5 ov clear", OPW | 24'h800, 24'd1, 24'd0, 1'b0, 8'd0);
    // R6 io sign
    run("R6 io neg", OPW | 24'h1000, 24'd1, 24'h800001, 1'b0, 8'd0);
    run("R6 io pos", OPW | 24'h1000, 24'd1, 24'h000001, 1'b0, 8'd0);
    // R7 switches
    run("R7 match", OPW | 24'h24, 24'd1, 24'd0, 1'b1, 8'h04);
    run("R7 miss", OPW | 24'h24, 24'd1, 24'd0, 1'b1, 8'h5B);
    // R8 OR and invert
    run("R8 or", OPW | 24'h500, 24'd3, 24'd0, 1'b1, 8'd0);
    run("R8 inv", OPW | 24'h40500, 24'd3, 24'd0, 1'b1, 8'd0);
    // R9 nothing selected
    run("R9 plain", OPW, 24'd0, 24'd0, 1'b0, 8'hFF);
    run("R9 inverted", OPW | 24'h40000, 24'd0, 24'd0, 1'b0, 8'hFF);
    // R2 near-miss opcodes
    for (int b = 19; b < 24; b++)
      run("R2 near miss", (OPW ^ (24'd1 << b)) | 24'h41FFF, 24'd0, 24'd0, 1'b0, 8'hFF);

    // R10 / R11 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    instr = OPW | 24'h900; acc = 24'd0; io_reg = '0; ovf = 1'b1; sense_sw = '0;
    in_valid = 1'b1;
    @(negedge clk);
    check("R10 latency", res_valid, 1'b1);
    check("R10 stall ready", in_ready, 1'b0);
    check("R10 first skip", res_skip, 1'b1);
    instr = OPW | 24'h40900;   // would give skip 0 if taken
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10 held", res_skip, 1'b1);
      check("R11 no pulse in stall", ovf_clear, 1'b0);
    end
    in_valid = 1'b0;
    res_ready = 1'b1;
    #1;
    check("R11 pulse on drain", ovf_clear, 1'b1);
    @(negedge clk);
    check("R10 drained", res_valid, 1'b0);
    check("R11 pulse ends", ovf_clear, 1'b0);

    // random transfers, constrained toward skip words
    void'($urandom(32'd4242));
    for (int n = 0; n < 400; n++) begin
      logic [23:0] w, a, io;
      logic [7:0] sw;
      logic ov;
      w = 24'($urandom);
      if ($urandom_range(3) != 0) w[23:19] = 5'b11010;
      if ($urandom_range(3) == 0) w[7:0] = 8'd0;
      a = 24'($urandom);
      if ($urandom_range(5) == 0) a = 24'd0;
      io = 24'($urandom);
      ov = 1'($urandom);
      sw = 8'($urandom);
      run("R8 random", w, a, io, ov, sw);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule